// File: doc/BRIEF.md
# CMI Line Decoder with NRZ Bypass

This block is the front end of an optical E1 receive path. In CMI mode it takes a stream of line chips, two chips per bit, from an external clock-recovery stage. That stage supplies the chip value and a strobe for each chip. The block groups the chips into pairs and decodes each pair into binary. It presents the result as dual-rail mark pulses, so that a downstream HDB3 post-decoder can consume them. The decoder does not correct invalid pairs. It zeroes them and flags them.

Pair alignment is found by hunting. When a run of consecutive invalid pairs reaches a configured length, the pairing boundary moves by one chip.

In NRZ mode the decode path is bypassed. A separate data input is captured on the falling edge of an externally supplied receive clock. That clock is synchronised into the block clock domain first. No symbol errors are reported in this mode.

Top module: `cmi_nrz_rx_front`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `rail_p`, `rail_n`, `nrz_q`, `bit_stb` and `sym_err` are all 0.
- R2: In CMI mode a chip pair is written as {earlier chip, later chip}. Pair 01 decodes to a zero (`rail_p`=0, `rail_n`=0). Pair 11 decodes to a positive mark (`rail_p`=1, `rail_n`=0). Pair 00 decodes to a negative mark (`rail_p`=0, `rail_n`=1). The two rails are never 1 together.
- R3: The decoded result is registered. It appears on the clock edge that samples the second chip's strobe and holds until the next pair completes. `bit_stb` is 1 for exactly that one cycle.
- R4: Pair 10 is invalid. It drives both rails to 0 and raises `sym_err` (together with `bit_stb`) for a single cycle.
- R5: After SLIP_LIMIT (default 4) consecutive invalid pairs, the pair boundary shifts by one chip. The later chip of the last invalid pair becomes the earlier chip of the next pair. Any valid pair clears the run count, so shorter runs never shift alignment.
- R6: With `nrz_sel`=1, `nrz_q` takes the value of `nrz_din` at each falling edge of `ext_rclk`, and `bit_stb` pulses for one cycle. Rising edges of `ext_rclk` do not change `nrz_q`. Both inputs pass through SYNC_STAGES flip-flops before use.
- R7: With `nrz_sel`=1, `rail_p`, `rail_n` and `sym_err` stay 0, whatever arrives on `chip_in`/`chip_stb`.
- R8: While `nrz_sel`=1 the pairing state is cleared. The first chip strobed after returning to CMI mode is the earlier chip of a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all state is updated on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| nrz_sel | input | 1 | 1 = NRZ bypass, 0 = CMI decode |
| chip_stb | input | 1 | One-cycle strobe from clock recovery, marking a valid chip |
| chip_in | input | 1 | CMI line chip value, sampled when `chip_stb`=1 |
| ext_rclk | input | 1 | External receive clock for NRZ mode (asynchronous) |
| nrz_din | input | 1 | NRZ data, captured on the falling edge of `ext_rclk` |
| rail_p | output | 1 | Positive-mark rail for the HDB3 post-decoder |
| rail_n | output | 1 | Negative-mark rail for the HDB3 post-decoder |
| nrz_q | output | 1 | Captured NRZ data bit |
| bit_stb | output | 1 | One-cycle pulse for each new output bit |
| sym_err | output | 1 | One-cycle pulse on an invalid CMI pair |

## Verification
The bench builds the block with SLIP_LIMIT=4 and SYNC_STAGES=2. These defaults keep a full hunt short enough to drive by hand: a one-chip misalignment produces exactly four flagged pairs and then decodes cleanly. A run of three invalid pairs broken by a valid one shows that the run counter clears. The two-stage synchroniser puts an NRZ capture three block cycles after the falling clock edge. The bench therefore holds `ext_rclk` in each phase long enough to tell a rising-edge capture from a falling-edge one.

// File: rtl/cmi_rx_pkg.sv
package cmi_rx_pkg;

  typedef enum logic {
    PH_EARLY = 1'b0,
    PH_LATE  = 1'b1
  } pair_phase_e;

  typedef struct packed {
    logic mark_p;
    logic mark_n;
    logic bad;
  } cmi_sym_t;

  // Pair is {earlier chip, later chip}.
  function automatic cmi_sym_t cmi_decode(input logic [1:0] pair);
    cmi_sym_t s;
    s = '0;
    unique case (pair)
      2'b01: s = '{mark_p: 1'b0, mark_n: 1'b0, bad: 1'b0};
      2'b11: s = '{mark_p: 1'b1, mark_n: 1'b0, bad: 1'b0};
      2'b00: s = '{mark_p: 1'b0, mark_n: 1'b1, bad: 1'b0};
      default: s = '{mark_p: 1'b0, mark_n: 1'b0, bad: 1'b1};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cmi_pair_align.sv
module cmi_pair_align
  import cmi_rx_pkg::*;
#(
  parameter int SLIP_LIMIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_clr,
  input  logic       chip_stb,
  input  logic       chip_in,
  output logic       pair_vld,
  output logic [1:0] pair,
  output logic       slip_evt,
  output logic       phase_late
);
  localparam int CW = $clog2(SLIP_LIMIT + 1);

  pair_phase_e   ph_q;
  logic          early_q;
  logic [CW-1:0] run_q;
  logic          pair_bad;

  assign pair_vld   = chip_stb && (ph_q == PH_LATE) && !hold_clr;
  assign pair       = {early_q, chip_in};
  assign pair_bad   = pair_vld && cmi_decode(pair).bad;
  assign slip_evt   = pair_bad && (run_q == CW'(SLIP_LIMIT - 1));
  assign phase_late = (ph_q == PH_LATE);

  always_ff @(posedge clk) begin
    if (!rst_n || hold_clr) begin
      ph_q    <= PH_EARLY;
      early_q <= 1'b0;
      run_q   <= '0;
    end else if (slip_evt) begin
      early_q <= chip_in;
      ph_q    <= PH_LATE;
      run_q   <= '0;
    end else if (pair_vld) begin
      ph_q  <= PH_EARLY;
      run_q <= pair_bad ? run_q + 1'b1 : '0;
    end else if (chip_stb) begin
      early_q <= chip_in;
      ph_q    <= PH_LATE;
    end
  end

endmodule

// File: rtl/cmi_sym_decode.sv
module cmi_sym_decode
  import cmi_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bypass,
  input  logic       pair_vld,
  input  logic [1:0] pair,
  output logic       rail_p,
  output logic       rail_n,
  output logic       sym_err,
  output logic       sym_stb
);
  cmi_sym_t sym;
  assign sym = cmi_decode(pair);

  always_ff @(posedge clk) begin
    if (!rst_n || bypass) begin
      rail_p  <= 1'b0;
      rail_n  <= 1'b0;
      sym_err <= 1'b0;
      sym_stb <= 1'b0;
    end else begin
      sym_stb <= pair_vld;
      sym_err <= pair_vld && sym.bad;
      if (pair_vld) begin
        rail_p <= sym.mark_p;
        rail_n <= sym.mark_n;
      end
    end
  end

endmodule

// File: rtl/nrz_capture.sv
module nrz_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ext_rclk,
  input  logic nrz_din,
  output logic nrz_q,
  output logic nrz_stb
);
  logic [SYNC_STAGES:0]   rclk_sh;
  logic [SYNC_STAGES-1:0] din_sh;
  logic                   fall;

  // Data and clock see the same number of stages, so they stay aligned.
  assign fall = rclk_sh[SYNC_STAGES] && !rclk_sh[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rclk_sh <= '0;
      din_sh  <= '0;
      nrz_q   <= 1'b0;
      nrz_stb <= 1'b0;
    end else begin
      rclk_sh <= {rclk_sh[SYNC_STAGES-1:0], ext_rclk};
      din_sh  <= {din_sh[SYNC_STAGES-2:0], nrz_din};
      nrz_stb <= enable && fall;
      if (enable && fall) nrz_q <= din_sh[SYNC_STAGES-1];
    end
  end

endmodule

// File: rtl/cmi_nrz_rx_front.sv
module cmi_nrz_rx_front #(
  parameter int SLIP_LIMIT  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nrz_sel,
  input  logic chip_stb,
  input  logic chip_in,
  input  logic ext_rclk,
  input  logic nrz_din,
  output logic rail_p,
  output logic rail_n,
  output logic nrz_q,
  output logic bit_stb,
  output logic sym_err
);
  logic       pair_vld;
  logic [1:0] pair;
  logic       slip_evt;
  logic       phase_late;
  logic       cmi_stb;
  logic       nrz_stb;

  cmi_pair_align #(.SLIP_LIMIT(SLIP_LIMIT)) u_align (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_clr   (nrz_sel),
    .chip_stb   (chip_stb),
    .chip_in    (chip_in),
    .pair_vld   (pair_vld),
    .pair       (pair),
    .slip_evt   (slip_evt),
    .phase_late (phase_late)
  );

  cmi_sym_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .bypass   (nrz_sel),
    .pair_vld (pair_vld),
    .pair     (pair),
    .rail_p   (rail_p),
    .rail_n   (rail_n),
    .sym_err  (sym_err),
    .sym_stb  (cmi_stb)
  );

  nrz_capture #(.SYNC_STAGES(SYNC_STAGES)) u_nrz (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (nrz_sel),
    .ext_rclk (ext_rclk),
    .nrz_din  (nrz_din),
    .nrz_q    (nrz_q),
    .nrz_stb  (nrz_stb)
  );

  assign bit_stb = cmi_stb | nrz_stb;

endmodule

// File: rtl/cmi_nrz_rx_front_chk.sv
module cmi_nrz_rx_front_chk (
  input logic clk,
  input logic rst_n,
  input logic nrz_sel,
  input logic rail_p,
  input logic rail_n,
  input logic sym_err,
  input logic bit_stb,
  input logic slip_evt,
  input logic phase_late
);
  p_rails_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rail_p && rail_n));

  p_err_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sym_err |=> !sym_err);

  p_err_zero_rails_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sym_err |-> (!rail_p && !rail_n && bit_stb));

  p_slip_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_evt && !nrz_sel) |=> phase_late);

  p_nrz_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (nrz_sel && $past(nrz_sel)) |-> (!sym_err && !rail_p && !rail_n));

  p_nrz_phase_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nrz_sel |=> !phase_late);

endmodule

bind cmi_nrz_rx_front cmi_nrz_rx_front_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .nrz_sel    (nrz_sel),
  .rail_p     (rail_p),
  .rail_n     (rail_n),
  .sym_err    (sym_err),
  .bit_stb    (bit_stb),
  .slip_evt   (slip_evt),
  .phase_late (phase_late)
);

// File: tb/cmi_nrz_rx_front_tb_top.sv
`timescale 1ns/1ps
module cmi_nrz_rx_front_tb_top;
  logic clk = 1'b0;
  logic rst_n, nrz_sel, chip_stb, chip_in, ext_rclk, nrz_din;
  logic rail_p, rail_n, nrz_q, bit_stb, sym_err;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmi_nrz_rx_front #(.SLIP_LIMIT(4), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .nrz_sel(nrz_sel), .chip_stb(chip_stb),
    .chip_in(chip_in), .ext_rclk(ext_rclk), .nrz_din(nrz_din),
    .rail_p(rail_p), .rail_n(rail_n), .nrz_q(nrz_q), .bit_stb(bit_stb),
    .sym_err(sym_err)
  );

  // {pair[1:0], exp_rail_p, exp_rail_n, exp_err}
  localparam logic [4:0] VEC [8] = '{
    5'b01_00_0, 5'b11_10_0, 5'b00_01_0, 5'b11_10_0,
    5'b10_00_1, 5'b00_01_0, 5'b01_00_0, 5'b10_00_1
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b (p,n,err,stb)", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic send_chip(input logic c);
    chip_in = c; chip_stb = 1'b1;
    @(negedge clk);
    chip_stb = 1'b0;
  endtask

  task automatic send_pair(input logic [1:0] p);
    send_chip(p[1]);
    @(negedge clk);
    send_chip(p[0]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rclk_cycle(input logic d);
    nrz_din = d;
    ext_rclk = 1'b1; repeat (5) @(negedge clk);
    ext_rclk = 1'b0; repeat (6) @(negedge clk);
  endtask

  initial begin
    nrz_sel = 1'b0; chip_stb = 1'b0; chip_in = 1'b0;
    ext_rclk = 1'b0; nrz_din = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset", {rail_p, rail_n, sym_err, bit_stb}, 4'b0000);
    chk1("R1 reset nrz_q", nrz_q, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {rail_p, rail_n, sym_err, bit_stb}, 4'b0000);

    // Table walk: R2/R4 decode values
    for (int i = 0; i < 8; i++) begin
      send_pair(VEC[i][4:3]);
      chk("R2/R4 vector", {rail_p, rail_n, sym_err, bit_stb}, {VEC[i][2:0], 1'b1});
    end

    // R3: held and strobe one cycle
    send_pair(2'b11);
    chk("R3 update", {rail_p, rail_n, sym_err, bit_stb}, 4'b1001);
    repeat (3) @(negedge clk);
    chk("R3 hold", {rail_p, rail_n, sym_err, bit_stb}, 4'b1000);
    send_chip(1'b0);
    chk("R3 no strobe on first chip", {rail_p, rail_n, sym_err, bit_stb}, 4'b1000);
    send_chip(1'b0);
    chk("R3 back-to-back chips", {rail_p, rail_n, sym_err, bit_stb}, 4'b0101);
    @(negedge clk);
    chk("R4 err single pulse precheck", {sym_err, bit_stb}, 2'b00);

    // R5: one-chip misalignment slips after four invalid pairs
    do_reset();
    send_chip(1'b1);
    for (int k = 0; k < 4; k++) begin
      send_chip(1'b0);
      chk("R5 misaligned pair invalid", {rail_p, rail_n, sym_err, bit_stb}, 4'b0011);
      send_chip(1'b1);
    end
    // After slip, the last 0 pairs with this 1 -> zero
    chk("R5 slipped pair", {rail_p, rail_n, sym_err, bit_stb}, 4'b0001);
    send_pair(2'b11);
    chk("R5 aligned mark", {rail_p, rail_n, sym_err, bit_stb}, 4'b1001);

    // R5: three invalid then valid clears the run
    do_reset();
    for (int k = 0; k < 3; k++) send_pair(2'b10);
    send_pair(2'b01);
    for (int k = 0; k < 3; k++) send_pair(2'b10);
    send_pair(2'b11);
    chk("R5 no slip below limit", {rail_p, rail_n, sym_err, bit_stb}, 4'b1001);

    // R6/R7: NRZ bypass
    nrz_sel = 1'b1;
    @(negedge clk);
    rclk_cycle(1'b1);
    chk1("R6 capture 1 on fall", nrz_q, 1'b1);
    rclk_cycle(1'b0);
    chk1("R6 capture 0 on fall", nrz_q, 1'b0);
    nrz_din = 1'b1;
    ext_rclk = 1'b1; repeat (6) @(negedge clk);
    chk1("R6 rising edge ignored", nrz_q, 1'b0);
    nrz_din = 1'b0;
    ext_rclk = 1'b0;
    repeat (3) @(negedge clk);
    chk1("R6 strobe on fall", bit_stb, 1'b1);
    chk1("R6 value at fall", nrz_q, 1'b0);
    send_pair(2'b10);
    chk("R7 nrz no error", {rail_p, rail_n, sym_err, bit_stb}, 4'b0000);
    send_pair(2'b11);
    chk("R7 nrz rails quiet", {rail_p, rail_n, sym_err, bit_stb}, 4'b0000);

    // R8: stray chip in NRZ, then back to CMI
    send_chip(1'b0);
    nrz_sel = 1'b0;
    @(negedge clk);
    send_pair(2'b11);
    chk("R8 phase restart", {rail_p, rail_n, sym_err, bit_stb}, 4'b1001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule